// File: doc/BRIEF.md
# Fourteen-Clock Oversampled UART

This block is a serial port with a small word-addressed register bus. It uses a fixed 8-N-1 frame, and every serial bit lasts fourteen sample clocks. A sample clock comes from dividing the system clock by a programmable rate value. Software sets the rate, the control word, the receive sample point, the trigger and timeout levels, and the flow-control options. It then moves characters through a single data address: a write queues a byte for transmission and a read takes the oldest received entry.

The receiver has no fixed mid-bit sample. It counts a programmable offset of sample clocks from the detected falling start edge and samples data bit k at that offset plus 14·k. Each received entry keeps its own framing-error and break flags. A status word collects level-type conditions (receive trigger, receive timeout, transmit level) and sticky conditions (overrun, break, framing error, transmit-level reached). Each sticky condition is cleared by writing a one to it. A single interrupt line combines these status bits through three enable groups. Optional automatic RTS and CTS handling has its own thresholds and polarity.

Top module: `uart14`

## Requirements
- R1: With rate value N (address 4), every transmitted bit lasts (N+1)·14 clocks. A frame is a low start bit, then 8 data bits LSB first, then a high stop bit. The line idles high.
- R2: The receiver samples data bit k at O+14·k sample clocks after it detects the falling start edge, where O is control bits 13:9. The stop bit is sampled at O+112.
- R3: A read at address 0 returns the oldest received entry and removes it. The character is in bits 7:0, bit 9 is the framing-error flag and bit 10 is the break flag. An empty FIFO reads as 0x100 (bit 8 set) and its state does not change.
- R4: Address 1 reads the transmit FIFO count in bits 15:8 and the receive FIFO count in bits 7:0.
- R5: A zero stop bit sets bit 9 in the stored entry and sticky status bit 3 (address 2). A frame that has all-zero data and a zero stop bit is a break: it sets entry bits 9 and 10 and status bit 4, not status bit 3. Writing a one to a sticky status bit clears it.
- R6: The receive FIFO holds 64 entries. A character that arrives while it is full is dropped and sets sticky status bit 5.
- R7: Status bit 1 is high while the receive count is at least the trigger level. Control bits 4:2 select the level: codes 0..5 give 1, 4, 8, 16, 32, 48, and codes 6 and 7 give 48.
- R8: Status bit 0 is high while the transmit count is at most the level in control bits 1:0 (codes 0..3 give 0, 4, 8, 16). Sticky status bit 6 is set each time bit 0 goes from low to high.
- R9: Control bits 17:16 select the receive timeout: code 0 disables it, and codes 1..3 give 4, 8 or 16 character times (one character time is 140 sample clocks). Status bit 2 rises after that much idle time with the receive FIFO non-empty. It drops on a read.
- R10: When control bit 18 is set, rts_out is 0 while the receive count is below the threshold and 1 at or above it. Control bits 20:19 select the threshold: codes 0..3 give 8, 16, 32, 48. Control bit 21 inverts rts_out.
- R11: When control bit 14 is set, a new frame starts only while cts_in equals control bit 15.
- R12: Control bit 8 forces txd low.
- R13: irq is the OR of three terms: control bit 7 AND (status 5 OR 4 OR 3), control bit 6 AND (status 2 OR 1), and control bit 5 AND status 6.
- R14: A receive push and a data read in the same clock leave the receive count unchanged and keep the entries in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive FIFO at address 0) |
| addr | input | 3 | Word address: 0 data, 1 level, 2 status, 3 control, 4 rate |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_in | input | 1 | Clear-to-send input |
| rts_out | output | 1 | Request-to-send output |
| irq | output | 1 | Combined interrupt |

## Verification
The risky overlap is a received character being written into the receive FIFO in the same clock that the bus reads the data register. If that case is handled wrong, the count drifts or an entry is lost. The bench holds one entry in the FIFO, starts a second frame, and moves the read across a sixteen-clock window around the expected push cycle, so one of those reads must coincide with the push. After each run it expects a count of exactly one, then the older byte, then the newer byte, and finally an empty FIFO.

// File: rtl/uart14.sv
module uart14 #(
  parameter int DEPTH = 64,
  parameter int SPB = 14,
  parameter int OFF_W = 5
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        rxd,
  output logic        txd,
  input  logic        cts_in,
  output logic        rts_out,
  output logic        irq
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int SW  = $clog2(SPB);
  localparam int RWW = (OFF_W > SW) ? OFF_W : SW;
  localparam int TW  = $clog2(160 * SPB + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [21:0] ctrl;
  logic [7:0]  rate, pre;
  logic        tick;
  assign tick = (pre >= rate);

  logic [1:0] tx_lvl_sel, tmo_sel, rts_sel;
  logic [2:0] rx_lvl_sel;
  logic [OFF_W-1:0] offs;
  logic tx_ie, rx_ie, err_ie, brk_force, cts_en, cts_inv, rts_en, rts_inv;
  assign tx_lvl_sel = ctrl[1:0];
  assign rx_lvl_sel = ctrl[4:2];
  assign tx_ie      = ctrl[5];
  assign rx_ie      = ctrl[6];
  assign err_ie     = ctrl[7];
  assign brk_force  = ctrl[8];
  assign offs       = ctrl[9 +: OFF_W];
  assign cts_en     = ctrl[14];
  assign cts_inv    = ctrl[15];
  assign tmo_sel    = ctrl[17:16];
  assign rts_en     = ctrl[18];
  assign rts_sel    = ctrl[20:19];
  assign rts_inv    = ctrl[21];

  logic unused_bits;
  assign unused_bits = ^wdata[31:22];

  logic data_acc, st_wr;
  assign data_acc = (addr == 3'd0);
  assign st_wr    = wr_en && (addr == 3'd2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0; rate <= '0; pre <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (wr_en && addr == 3'd3) ctrl <= wdata[21:0];
      if (wr_en && addr == 3'd4) rate <= wdata[7:0];
    end

  logic [2:0] rx_s;
  logic [1:0] cts_s;
  logic rx_line, rx_fall;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin rx_s <= 3'b111; cts_s <= 2'b00; end
    else begin rx_s <= {rx_s[1:0], rxd}; cts_s <= {cts_s[0], cts_in}; end
  assign rx_line = rx_s[1];
  assign rx_fall = rx_s[2] & ~rx_s[1];

  // receiver
  logic rx_busy;
  logic [RWW-1:0] rx_wait;
  logic [3:0] rx_idx;
  logic [7:0] rx_sh;
  logic rx_done, rx_err, rx_brk;
  assign rx_done = rx_busy && tick && rx_wait == '0 && rx_idx == 4'd8;
  assign rx_err  = ~rx_line;
  assign rx_brk  = rx_err && rx_sh == 8'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_wait <= '0; rx_idx <= '0; rx_sh <= '0;
    end else if (!rx_busy) begin
      if (rx_fall) begin
        rx_busy <= 1'b1; rx_wait <= RWW'(offs); rx_idx <= '0;
      end
    end else if (tick) begin
      if (rx_wait == '0) begin
        if (rx_idx == 4'd8) rx_busy <= 1'b0;
        else begin
          rx_sh  <= {rx_line, rx_sh[7:1]};
          rx_idx <= rx_idx + 1'b1;
        end
        rx_wait <= RWW'(SPB - 1);
      end else rx_wait <= rx_wait - 1'b1;
    end

  // receive FIFO
  logic [9:0] rx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic rx_push, rx_pop;
  assign rx_push = rx_done && rx_cnt != FULL;
  assign rx_pop  = rd_en && data_acc && rx_cnt != '0;

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= {rx_brk, rx_err, rx_sh};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  // transmit FIFO and shifter
  logic [7:0] tx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic tx_push, tx_start, tx_busy, cts_ok;
  logic [SW-1:0] tx_wait;
  logic [3:0] tx_idx;
  logic [9:0] tx_sh;
  assign cts_ok   = !cts_en || (cts_s[1] == cts_inv);
  assign tx_push  = wr_en && data_acc && tx_cnt != FULL;
  assign tx_start = !tx_busy && tx_cnt != '0 && cts_ok;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      tx_busy <= 1'b0; tx_wait <= '0; tx_idx <= '0; tx_sh <= '1;
    end else begin
      if (tx_push)  tx_wp <= tx_wp + 1'b1;
      if (tx_start) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_start);
      if (tx_start) begin
        tx_busy <= 1'b1; tx_sh <= {1'b1, tx_mem[tx_rp], 1'b0};
        tx_wait <= SW'(SPB - 1); tx_idx <= '0;
      end else if (tx_busy && tick) begin
        if (tx_wait == '0) begin
          if (tx_idx == 4'd9) tx_busy <= 1'b0;
          else begin
            tx_sh  <= {1'b1, tx_sh[9:1]};
            tx_idx <= tx_idx + 1'b1;
          end
          tx_wait <= SW'(SPB - 1);
        end else tx_wait <= tx_wait - 1'b1;
      end
    end

  assign txd = !brk_force && (!tx_busy || tx_sh[0]);

  // thresholds
  logic [CW-1:0] rx_thr, tx_thr, rts_thr;
  logic [TW-1:0] tmo_lim, tmo_cnt;
  always_comb begin
    case (rx_lvl_sel)
      3'd0: rx_thr = CW'(1);
      3'd1: rx_thr = CW'(4);
      3'd2: rx_thr = CW'(8);
      3'd3: rx_thr = CW'(16);
      3'd4: rx_thr = CW'(32);
      default: rx_thr = CW'(48);
    endcase
    case (tx_lvl_sel)
      2'd0: tx_thr = CW'(0);
      2'd1: tx_thr = CW'(4);
      2'd2: tx_thr = CW'(8);
      default: tx_thr = CW'(16);
    endcase
    case (rts_sel)
      2'd0: rts_thr = CW'(8);
      2'd1: rts_thr = CW'(16);
      2'd2: rts_thr = CW'(32);
      default: rts_thr = CW'(48);
    endcase
    case (tmo_sel)
      2'd1: tmo_lim = TW'(40 * SPB);
      2'd2: tmo_lim = TW'(80 * SPB);
      2'd3: tmo_lim = TW'(160 * SPB);
      default: tmo_lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmo_cnt <= '0;
    else if (rx_cnt == '0 || rx_busy || rx_push || rx_pop) tmo_cnt <= '0;
    else if (tick && tmo_cnt != '1) tmo_cnt <= tmo_cnt + 1'b1;

  logic st_tx, st_rxt, st_tmo, tx_prev;
  logic f_oe, f_brk, f_fe, f_txi;
  assign st_tx  = tx_cnt <= tx_thr;
  assign st_rxt = rx_cnt >= rx_thr;
  assign st_tmo = tmo_sel != 2'd0 && tmo_cnt >= tmo_lim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      f_oe <= 1'b0; f_brk <= 1'b0; f_fe <= 1'b0; f_txi <= 1'b0; tx_prev <= 1'b1;
    end else begin
      tx_prev <= st_tx;
      f_oe  <= (f_oe  & ~(st_wr & wdata[5])) | (rx_done && rx_cnt == FULL);
      f_brk <= (f_brk & ~(st_wr & wdata[4])) | (rx_done && rx_brk);
      f_fe  <= (f_fe  & ~(st_wr & wdata[3])) | (rx_done && rx_err && !rx_brk);
      f_txi <= (f_txi & ~(st_wr & wdata[6])) | (st_tx && !tx_prev);
    end

  logic [6:0] status;
  assign status = {f_txi, f_oe, f_brk, f_fe, st_tmo, st_rxt, st_tx};
  assign irq = (err_ie & (f_oe | f_brk | f_fe)) | (rx_ie & (st_tmo | st_rxt)) | (tx_ie & f_txi);
  assign rts_out = rts_inv ^ (rts_en && rx_cnt >= rts_thr);

  logic [9:0] rx_head;
  assign rx_head = rx_mem[rx_rp];
  always_comb
    case (addr)
      3'd0: rdata = (rx_cnt == '0) ? 32'h100 : {21'd0, rx_head[9], rx_head[8], 1'b0, rx_head[7:0]};
      3'd1: rdata = {16'd0, 8'(tx_cnt), 8'(rx_cnt)};
      3'd2: rdata = {25'd0, status};
      3'd3: rdata = {10'd0, ctrl};
      3'd4: rdata = {24'd0, rate};
      default: rdata = '0;
    endcase

  // R6
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_cnt == FULL) |=> rdata[5] || addr != 3'd2 || f_oe);
  // R14
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_pop) |=> $stable(rx_cnt));
  // R14
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop) |=> rx_cnt == $past(rx_cnt) + 1'b1);
  // R11
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_en && cts_s[1] != cts_inv && !tx_busy && $stable(ctrl)) |=> !tx_busy);
  // R1
  stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_busy) && !brk_force) |-> txd);
  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && data_acc && rx_cnt == '0) |=> $stable(rx_cnt));
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL && tx_cnt <= FULL);
endmodule

// File: tb/uart14_test.sv
`timescale 1ns/1ps
module uart14_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  wire  [31:0] rdata;
  logic rxd = 1'b1, cts_in = 1'b0;
  wire  txd, rts_out, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  uart14 uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
              .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .cts_in(cts_in),
              .rts_out(rts_out), .irq(irq));

  always #2.5 clk = ~clk;

  localparam logic [31:0] BASE = 32'(20) << 9;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit stop);
    @(negedge clk);
    for (int s = 0; s < 10; s++) begin
      rxd = (s == 0) ? 1'b0 : (s == 9) ? stop : d[s-1];
      repeat (14) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic tx_capture(input int r, output logic [9:0] f);
    int n = 0;
    f = '1;
    while (txd !== 1'b0 && n < 4000) begin @(negedge clk); n++; end
    repeat (7 * (r + 1)) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      f[k] = txd;
      if (k < 9) repeat (14 * (r + 1)) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [9:0] f;
    logic [7:0] bytes [5] = '{8'h00, 8'h55, 8'hA5, 8'hFF, 8'h3C};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state (R3, R4, R8)
    peek(3'd1, v); chk("R4 reset level", v, 32'h0);
    peek(3'd2, v); chk("R8 reset status", v, 32'h1);
    peek(3'd0, v); chk("R3 empty read", v, 32'h100);
    chk("R1 idle txd", {31'd0, txd}, 32'h1);
    chk("R13 reset irq", {31'd0, irq}, 32'h0);

    // R1: transmit frames
    wr(3'd3, BASE);
    foreach (bytes[i]) begin
      wr(3'd0, {24'd0, bytes[i]});
      tx_capture(0, f);
      chk("R1 tx frame", {22'd0, f}, {22'd0, 1'b1, bytes[i], 1'b0});
    end
    wr(3'd4, 32'd2);
    wr(3'd0, 32'h96);
    tx_capture(2, f);
    chk("R1 tx frame rate 2", {22'd0, f}, {22'd0, 1'b1, 8'h96, 1'b0});
    repeat (60) @(negedge clk);
    wr(3'd4, 32'd0);

    // R2: sample offset sweep
    for (int o = 15; o <= 24; o++) begin
      logic [7:0] d;
      d = 8'((o * 37) ^ 8'h5A);
      wr(3'd3, 32'(o) << 9);
      send_frame(d, 1'b1);
      repeat (4) @(negedge clk);
      peek(3'd1, v); chk("R4 rx level one", v, 32'h1);
      rd(3'd0, v); chk("R2 rx byte at offset", v, {24'd0, d});
    end
    wr(3'd3, 32'(6) << 9);
    send_frame(8'hB3, 1'b1);
    repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R2 early offset shifts sample", v, 32'h66);
    wr(3'd3, BASE);
    rd(3'd0, v); chk("R3 empty pop", v, 32'h100);
    peek(3'd1, v); chk("R3 empty pop keeps level", v, 32'h0);

    // R5: framing error and break
    send_frame(8'h41, 1'b0);
    repeat (4) @(negedge clk);
    peek(3'd2, v); chk("R5 framing status", v & 32'h18, 32'h08);
    rd(3'd0, v); chk("R5 framing entry", v, 32'h241);
    wr(3'd2, 32'h08);
    peek(3'd2, v); chk("R5 framing cleared", v & 32'h08, 32'h0);
    @(negedge clk); rxd = 1'b0;
    repeat (154) @(negedge clk); rxd = 1'b1;
    repeat (20) @(negedge clk);
    peek(3'd2, v); chk("R5 break status", v & 32'h18, 32'h10);
    rd(3'd0, v); chk("R5 break entry", v, 32'h600);
    wr(3'd2, 32'h10);
    peek(3'd2, v); chk("R5 break cleared", v & 32'h10, 32'h0);

    // R7: receive trigger sweep
    for (int c = 0; c < 6; c++) begin
      int thr;
      thr = (c == 0) ? 1 : (c == 5) ? 48 : (2 << c);
      wr(3'd3, BASE | (32'(c) << 2));
      peek(3'd2, v); chk("R7 trigger clear when empty", v & 32'h2, 32'h0);
      for (int i = 1; i <= thr; i++) begin
        send_frame(8'(i), 1'b1);
        repeat (4) @(negedge clk);
        if (i == thr - 1) begin peek(3'd2, v); chk("R7 below trigger", v & 32'h2, 32'h0); end
        if (i == thr) begin peek(3'd2, v); chk("R7 at trigger", v & 32'h2, 32'h2); end
      end
      for (int i = 0; i < thr; i++) rd(3'd0, v);
      peek(3'd1, v); chk("R4 drained", v, 32'h0);
    end

    // R6 + R10: fill, RTS thresholds, overrun
    wr(3'd3, BASE | (32'h1 << 18));
    for (int i = 1; i <= 64; i++) begin
      send_frame(8'(i), 1'b1);
      repeat (4) @(negedge clk);
      if (i == 7)  chk("R10 rts below 8", {31'd0, rts_out}, 32'h0);
      if (i == 8) begin
        chk("R10 rts at 8", {31'd0, rts_out}, 32'h1);
        wr(3'd3, BASE | (32'h1 << 18) | (32'h3 << 19));
      end
      if (i == 47) chk("R10 rts below 48", {31'd0, rts_out}, 32'h0);
      if (i == 48) chk("R10 rts at 48", {31'd0, rts_out}, 32'h1);
    end
    peek(3'd2, v); chk("R6 no overrun at 64", v & 32'h20, 32'h0);
    send_frame(8'hEE, 1'b1);
    repeat (4) @(negedge clk);
    peek(3'd2, v); chk("R6 overrun flag", v & 32'h20, 32'h20);
    peek(3'd1, v); chk("R6 level stays 64", v, 32'h40);
    wr(3'd3, BASE | (32'h1 << 18) | (32'h3 << 19) | (32'h1 << 21));
    chk("R10 rts inverted", {31'd0, rts_out}, 32'h0);
    rd(3'd0, v); chk("R6 oldest kept", v, 32'h1);
    for (int i = 2; i <= 64; i++) rd(3'd0, v);
    chk("R6 newest kept, extra dropped", v, 32'h40);
    wr(3'd3, BASE | (32'h1 << 7));
    chk("R13 irq from overrun", {31'd0, irq}, 32'h1);
    wr(3'd2, 32'h20);
    chk("R13 irq after clear", {31'd0, irq}, 32'h0);

    // R9: receive timeout
    wr(3'd3, BASE | (32'h1 << 16) | (32'h5 << 2) | (32'h1 << 6));
    send_frame(8'h77, 1'b1);
    repeat (530) @(negedge clk);
    peek(3'd2, v); chk("R9 before timeout", v & 32'h4, 32'h0);
    chk("R13 no irq before timeout", {31'd0, irq}, 32'h0);
    repeat (60) @(negedge clk);
    peek(3'd2, v); chk("R9 timeout", v & 32'h4, 32'h4);
    chk("R13 irq on timeout", {31'd0, irq}, 32'h1);
    rd(3'd0, v); chk("R9 byte", v, 32'h77);
    peek(3'd2, v); chk("R9 cleared by read", v & 32'h4, 32'h0);

    // R8 + R11: CTS gating, transmit level
    wr(3'd3, BASE | (32'h1 << 14) | 32'h1 | (32'h1 << 5));
    cts_in = 1'b1;
    wr(3'd2, 32'h40);
    peek(3'd2, v); chk("R8 tx flag cleared", v & 32'h40, 32'h0);
    for (int i = 0; i < 6; i++) wr(3'd0, 32'h11 + 32'(i));
    peek(3'd1, v); chk("R4 tx level", v, 32'h600);
    peek(3'd2, v); chk("R8 above tx level", v & 32'h41, 32'h0);
    begin
      bit seen_low = 1'b0;
      repeat (200) begin @(negedge clk); if (txd == 1'b0) seen_low = 1'b1; end
      chk("R11 blocked by cts", {31'd0, seen_low}, 32'h0);
    end
    cts_in = 1'b0;
    tx_capture(0, f);
    chk("R11 sends after cts", {22'd0, f}, {22'd0, 1'b1, 8'h11, 1'b0});
    repeat (900) @(negedge clk);
    peek(3'd2, v); chk("R8 tx level reached", v & 32'h41, 32'h41);
    chk("R13 irq from tx", {31'd0, irq}, 32'h1);
    wr(3'd2, 32'h40);
    chk("R13 irq after tx clear", {31'd0, irq}, 32'h0);
    wr(3'd3, BASE | (32'h1 << 14) | (32'h1 << 15));
    wr(3'd0, 32'h5E);
    begin
      bit seen_low = 1'b0;
      repeat (100) begin @(negedge clk); if (txd == 1'b0) seen_low = 1'b1; end
      chk("R11 inverted blocks", {31'd0, seen_low}, 32'h0);
    end
    cts_in = 1'b1;
    tx_capture(0, f);
    chk("R11 inverted sends", {22'd0, f}, {22'd0, 1'b1, 8'h5E, 1'b0});
    repeat (150) @(negedge clk);
    cts_in = 1'b0;

    // R12: forced break
    wr(3'd3, BASE | (32'h1 << 8));
    @(negedge clk); chk("R12 forced low", {31'd0, txd}, 32'h0);
    wr(3'd3, BASE);
    @(negedge clk); chk("R12 released", {31'd0, txd}, 32'h1);

    // R14: pop swept across the push cycle
    for (int d = 0; d < 16; d++) begin
      logic [31:0] first;
      send_frame(8'h10 + 8'(d), 1'b1);
      repeat (4) @(negedge clk);
      fork
        send_frame(8'hC0 + 8'(d), 1'b1);
        begin repeat (126 + d) @(negedge clk); rd(3'd0, first); end
      join
      repeat (4) @(negedge clk);
      chk("R14 popped older", first, 32'h10 + 32'(d));
      peek(3'd1, v); chk("R14 level one", v, 32'h1);
      rd(3'd0, v); chk("R14 newer kept", v, 32'hC0 + 32'(d));
      peek(3'd1, v); chk("R14 empty after", v, 32'h0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule